// File: doc/BRIEF.md
# Supervisor reset pulse generator

This block produces the processor reset of a supply supervisor. Two independent conditions hold the processor in reset: a digital low-line flag, already synchronized to the block clock, that reports the supply below its threshold, and an active-low manual reset line that may come straight from a push-button, from logic, or from a watchdog output routed onto it. While either condition is present, reset is asserted. Once the last condition goes away, reset stays asserted for a fixed hold-off time, which is the number of prescaler ticks times the prescaler divide ratio, and only then releases.

The reset is driven in both polarities from the same timer. A status output shows when the hold-off timer is counting. The manual input passes through a two-stage synchronizer before it is used. After the block's own synchronous reset the supply is treated as low, so the processor reset starts asserted and the first release comes one full hold-off after start-up.

Top module: `supv_reset_gen`

## Requirements
- R1: `sys_rst_n` is 0 from the first clock edge that samples `low_line` = 1, and it stays 0 for as long as `low_line` stays 1.
- R2: With `man_rst_n` high, `sys_rst_n` rises exactly HOLD_CYCLES = HOLD_TICKS × PRESCALE edges after the first edge that samples `low_line` = 0, and not before.
- R3: `man_rst_n` = 0 asserts reset after the two-stage synchronizer: `sys_rst_n` is 0 from the third edge that samples it low, and stays 0 while it is held low.
- R4: After `man_rst_n` rises, with `low_line` = 0, `sys_rst_n` rises exactly HOLD_CYCLES + 2 edges after the first edge that samples it high.
- R5: `sys_rst` is always the logical inverse of `sys_rst_n`, during and after the block's own reset.
- R6: A cause that returns during a hold-off, including on the very edge at which the hold-off would expire, cancels it; release then comes HOLD_CYCLES after that cause clears again.
- R7: While `rst_n` is 0, `sys_rst_n` = 0 and `hold_busy` = 0; with no cause present, `sys_rst_n` rises HOLD_CYCLES edges after the first edge that samples `rst_n` = 1.
- R8: `hold_busy` = 1 exactly from the edge at which the hold-off starts until the edge at which `sys_rst_n` rises, and is 0 whenever a cause is present.
- R9: A `man_rst_n` low pulse lasting one clock cycle, as a routed watchdog timeout produces, yields a full hold-off; with both inputs idle the reset never asserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| low_line | input | 1 | Synchronized flag, 1 while the supply is below threshold |
| man_rst_n | input | 1 | Asynchronous manual reset, active low |
| sys_rst_n | output | 1 | Processor reset, active low |
| sys_rst | output | 1 | Processor reset, active high |
| hold_busy | output | 1 | 1 while the hold-off timer is counting |

## Verification
The two functions that can meet in one cycle are the expiry of the hold-off and the return of a reset cause. The bench starts a hold-off by clearing the low-line flag, counts edges to the one at which release is due, and raises the flag again in the cycle just before it, so that the comparison happens on exactly that edge. It then expects the reset to stay asserted with the busy flag low, and after the flag clears a second time it expects one complete new hold-off, measured edge by edge, rather than a shortened one.

// File: rtl/supv_pkg.sv
// Package: shared types of the supervisor reset generator.
// Assumes: nothing beyond IEEE 1800-2017.
package supv_pkg;

    // Phase of the reset sequence.
    typedef enum logic [1:0] {
        PH_CAUSE = 2'd0,   // a reset cause is present
        PH_HOLD  = 2'd1,   // causes gone, hold-off counting
        PH_FREE  = 2'd2    // reset released
    } supv_phase_e;

    // Width of a down-counter that must hold values 0 .. n-1.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/supv_sync.sv
// Module: supv_sync
// Does: brings an asynchronous level into the clk domain through a chain
//       of STAGES flip-flops.
// Assumes: STAGES >= 1; the reset value is the input's idle level so the
//       chain does not create a false event when rst_n releases.
module supv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single stage: capture the level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_many
            // Multi stage: shift the level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/supv_prescaler.sv
// Module: supv_prescaler
// Does: divides the clock while run is high and pulses tick once every DIV
//       cycles; restart puts the phase back to zero so the first tick comes
//       exactly DIV cycles after it.
// Assumes: DIV >= 1; restart and run are never both high.
module supv_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    import supv_pkg::*;

    localparam int CW = cnt_width(DIV);

    generate
        if (DIV == 1) begin : g_pass
            // No division: every running cycle is a tick.
            assign tick = run;
        end else begin : g_div
            logic [CW-1:0] phase;
            logic          at_end;

            assign at_end = (phase == CW'(DIV - 1));

            // Phase counter: cleared on restart, wraps at DIV-1 while running.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    phase <= '0;
                end else if (run) begin
                    phase <= at_end ? '0 : phase + 1'b1;
                end
            end

            assign tick = run && at_end;

            // R2: two ticks are never adjacent, the time base really divides.
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/supv_holdoff.sv
// Module: supv_holdoff
// Does: sequences the reset phases. Any cause forces PH_CAUSE; the first
//       cycle without a cause loads the tick counter and starts the
//       prescaler; the last tick of the count moves to PH_FREE.
// Assumes: tick only arrives while busy is high; TICKS >= 1.
module supv_holdoff #(
    parameter int TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic tick,
    output logic restart,
    output logic busy,
    output logic free_next
);
    import supv_pkg::*;

    localparam int CW = cnt_width(TICKS);

    supv_phase_e   phase_q, phase_d;
    logic [CW-1:0] left_q, left_d;

    // Next phase and next count.
    always_comb begin
        phase_d = phase_q;
        left_d  = left_q;
        restart = 1'b0;
        if (cause) begin
            phase_d = PH_CAUSE;
        end else begin
            unique case (phase_q)
                PH_CAUSE: begin
                    phase_d = PH_HOLD;
                    left_d  = CW'(TICKS - 1);
                    restart = 1'b1;
                end
                PH_HOLD: begin
                    if (tick) begin
                        if (left_q == '0) phase_d = PH_FREE;
                        else              left_d  = left_q - 1'b1;
                    end
                end
                default: phase_d = PH_FREE;
            endcase
        end
    end

    // Phase and count registers; power-up behaves as a present cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CAUSE;
            left_q  <= '0;
        end else begin
            phase_q <= phase_d;
            left_q  <= left_d;
        end
    end

    assign busy      = (phase_q == PH_HOLD);
    assign free_next = (phase_d == PH_FREE);

    // R6: a cause always wins, whatever the count was doing.
    a_r6_cause_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (phase_q == PH_CAUSE));

    // R8: a hold-off is only ever entered from the cause phase.
    a_r8_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(phase_q == PH_CAUSE));

    // R2: the count never exceeds its loaded value.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CW'(TICKS - 1));

endmodule

// File: rtl/supv_reset_gen.sv
// Module: supv_reset_gen (top)
// Does: combines the low-line flag and the synchronized manual reset into
//       one cause, runs the shared hold-off timer and registers both
//       polarities of the processor reset from it.
// Assumes: low_line is already in the clk domain; man_rst_n is asynchronous
//       and debounced elsewhere. Hold-off = HOLD_TICKS * PRESCALE cycles.
module supv_reset_gen #(
    parameter int PRESCALE   = 1000,
    parameter int HOLD_TICKS = 200,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_line,
    input  logic man_rst_n,
    output logic sys_rst_n,
    output logic sys_rst,
    output logic hold_busy
);

    localparam int HOLD_CYCLES = PRESCALE * HOLD_TICKS;

    logic man_sync_n;
    logic cause;
    logic restart;
    logic tick;
    logic busy;
    logic free_next;
    logic rst_n_q;
    logic rst_q;

    supv_sync #(
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (man_rst_n),
        .q     (man_sync_n)
    );

    assign cause = low_line || !man_sync_n;

    supv_holdoff #(
        .TICKS (HOLD_TICKS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (cause),
        .tick      (tick),
        .restart   (restart),
        .busy      (busy),
        .free_next (free_next)
    );

    supv_prescaler #(
        .DIV (PRESCALE)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (busy),
        .tick    (tick)
    );

    // Output registers: two flops, one per polarity, from the same decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_n_q <= 1'b0;
            rst_q   <= 1'b1;
        end else begin
            rst_n_q <= free_next;
            rst_q   <= !free_next;
        end
    end

    assign sys_rst_n = rst_n_q;
    assign sys_rst   = rst_q;
    assign hold_busy = busy;

    // R1: a low supply forces reset on the next edge.
    a_r1_low_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        low_line |=> !sys_rst_n);

    // R3: a synchronized manual press forces reset on the next edge.
    a_r3_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !man_sync_n |=> !sys_rst_n);

    // R5: the two output flops always disagree.
    a_r5_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst == !sys_rst_n);

    // R2: release only ends a hold-off that was running.
    a_r2_release_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(busy));

    // R8: the timer never runs while a cause is present.
    a_r8_busy_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> !hold_busy);

    // HOLD_CYCLES documents the resulting stretch; it must be positive.
    initial begin
        a_r2_hold_positive: assert (HOLD_CYCLES > 0);
    end

endmodule

// File: tb/sim_supv_reset_gen.sv
// Directed bench: each task drives one scenario at falling edges and checks
// the outputs at falling edges, counting edges from the requirements.
module sim_supv_reset_gen;

    localparam int PRESCALE   = 4;
    localparam int HOLD_TICKS = 5;
    localparam int HC         = PRESCALE * HOLD_TICKS;

    logic clk = 1'b0;
    logic rst_n;
    logic low_line;
    logic man_rst_n;
    logic sys_rst_n;
    logic sys_rst;
    logic hold_busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    supv_reset_gen #(
        .PRESCALE   (PRESCALE),
        .HOLD_TICKS (HOLD_TICKS),
        .SYNC_DEPTH (2)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_line  (low_line),
        .man_rst_n (man_rst_n),
        .sys_rst_n (sys_rst_n),
        .sys_rst   (sys_rst),
        .hold_busy (hold_busy)
    );

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Compare outputs with expectations; R5 is checked every time.
    task automatic chk(input logic exp_n, input logic exp_busy, input string tag);
        n_chk++;
        if (sys_rst_n !== exp_n || hold_busy !== exp_busy) begin
            n_fail++;
            $display("FAIL %s: sys_rst_n=%b hold_busy=%b expected %b %b",
                     tag, sys_rst_n, hold_busy, exp_n, exp_busy);
        end
        n_chk++;
        if (sys_rst !== ~exp_n) begin
            n_fail++;
            $display("FAIL R5 (%s): sys_rst=%b expected %b", tag, sys_rst, ~exp_n);
        end
    endtask

    // A cause was removed at this falling edge; the hold-off starts on edge
    // number lead and release is due on edge lead + HC.
    task automatic release_check(input int lead, input string tag);
        wait_neg(lead);
        chk(1'b0, 1'b1, {tag, " hold started"});
        wait_neg(HC - 1);
        chk(1'b0, 1'b1, {tag, " one edge before release"});
        wait_neg(1);
        chk(1'b1, 1'b0, {tag, " released"});
    endtask

    task automatic t_powerup_r7;
        rst_n = 1'b0; low_line = 1'b0; man_rst_n = 1'b1;
        wait_neg(3);
        chk(1'b0, 1'b0, "R7 during block reset");
        rst_n = 1'b1;
        release_check(1, "R7 power-up");
        wait_neg(10);
        chk(1'b1, 1'b0, "R9 idle inputs keep reset off");
    endtask

    task automatic t_low_line_r1_r2;
        low_line = 1'b1;
        wait_neg(1);
        chk(1'b0, 1'b0, "R1 low line asserts");
        wait_neg(HC + 7);
        chk(1'b0, 1'b0, "R1 held while low");
        low_line = 1'b0;
        release_check(1, "R2 low-line release");
    endtask

    task automatic t_manual_r3_r4;
        man_rst_n = 1'b0;
        wait_neg(2);
        chk(1'b1, 1'b0, "R3 before sync latency");
        wait_neg(1);
        chk(1'b0, 1'b0, "R3 manual asserts");
        wait_neg(HC + 3);
        chk(1'b0, 1'b0, "R3 held while pressed");
        man_rst_n = 1'b1;
        release_check(3, "R4 manual release");
    endtask

    task automatic t_abort_r6;
        low_line = 1'b1;
        wait_neg(2);
        low_line = 1'b0;
        wait_neg(8);
        chk(1'b0, 1'b1, "R8 busy mid hold-off");
        low_line = 1'b1;
        wait_neg(1);
        chk(1'b0, 1'b0, "R6 new cause cancels hold-off");
        low_line = 1'b0;
        release_check(1, "R6 restart after cancel");
    endtask

    // Cause returns on exactly the edge at which release is due.
    task automatic t_collide_r6;
        low_line = 1'b1;
        wait_neg(2);
        low_line = 1'b0;
        wait_neg(HC);
        chk(1'b0, 1'b1, "R6 last hold cycle");
        low_line = 1'b1;
        wait_neg(1);
        chk(1'b0, 1'b0, "R6 cause wins at expiry edge");
        low_line = 1'b0;
        release_check(1, "R6 full hold after collision");
    endtask

    task automatic t_overlap_r6;
        low_line = 1'b1; man_rst_n = 1'b0;
        wait_neg(4);
        low_line = 1'b0;
        wait_neg(HC + 5);
        chk(1'b0, 1'b0, "R3 manual still holds after supply recovers");
        man_rst_n = 1'b1;
        release_check(3, "R6 last cause manual");
        man_rst_n = 1'b0;
        wait_neg(4);
        low_line = 1'b1;
        wait_neg(1);
        man_rst_n = 1'b1;
        wait_neg(HC + 5);
        chk(1'b0, 1'b0, "R1 supply still holds after manual release");
        low_line = 1'b0;
        release_check(1, "R6 last cause low line");
    endtask

    // One-cycle low pulse, as a routed watchdog output would give.
    task automatic t_pulse_r9;
        man_rst_n = 1'b0;
        wait_neg(1);
        man_rst_n = 1'b1;
        wait_neg(2);
        chk(1'b0, 1'b0, "R9 short pulse asserts");
        release_check(1, "R9 short pulse full hold-off");
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; low_line = 1'b0; man_rst_n = 1'b1;
        t_powerup_r7();
        t_low_line_r1_r2();
        t_manual_r3_r4();
        t_abort_r6();
        t_collide_r6();
        t_overlap_r6();
        t_pulse_r9();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule